// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synchronous static memory with a pipelined command port that needs no idle cycle when the bus turns around. A read and a write each use the data bus in the same slot relative to their command. Because of this, any mix of reads and writes can be issued on consecutive clocks. Each cycle the block decodes one of six operations from the port: deselect, suspend, begin read, begin write, continue a read burst, or continue a write burst.

A load cycle takes an external address. A continue cycle reuses the access type of the last load and steps the address inside an aligned group of four words. The mode input picks the stepping order: linear or interleaved. Write data is taken from the bus two valid clocks after its command, and the byte selects choose which lanes are stored. A high clock enable freezes the whole pipeline, which inserts wait states.

The data bus is split into an input `dq_i`, an output `dq_o` and a drive enable `dq_t`, so that an external pad ring can build the tri-state pins.

Top module: `pipe_burst_sram`

## Requirements
- R1: While reset is high and after it is released, with no command issued, `dq_t` stays 0 even when `oe_n` is 0.
- R2: A clock edge with `cen_n` = 1 is ignored. Pipeline contents, burst position, stored data and `dq_o`/`dq_t` keep their values, and `dq_i` is not written.
- R3: A valid edge with `cs_n` = 0, `adv_ld` = 0 and `we_n` = 1 starts a read of `addr`. The word is driven on `dq_o`, with `dq_t` = 1, after the first valid edge that follows, so it can be sampled at the second valid edge.
- R4: A valid edge with `cs_n` = 0, `adv_ld` = 0 and `we_n` = 0 starts a write to `addr`. The word is taken from `dq_i` at the second valid edge after the command. Lane i is bits 8i+7..8i and is written only when `bws_n[i]` = 0.
- R5: On a valid edge with `adv_ld` = 1, the inputs `cs_n`, `we_n` and `addr` are ignored, and the access type of the last load is repeated. If the last load was a deselect, nothing is accessed.
- R6: With `burst_ilv` = 0 at the load, continuation n (n = 1, 2, 3, then wrapping) accesses offset (start + n) mod 4. Address bits above the lowest two stay those of the load.
- R7: With `burst_ilv` = 1 at the load, continuation n accesses offset start XOR (n mod 4). The mode is sampled only on load cycles.
- R8: Continuation writes take their lane mask from `bws_n` in the continuation cycle itself.
- R9: A valid edge with `cs_n` = 1 and `adv_ld` = 0 accesses nothing, and `dq_t` is 0 in that command's bus slot.
- R10: `dq_t` is 1 only when the slot holds a read and `oe_n` = 0. `oe_n` acts without a clock.
- R11: A read issued on the clock right after a write to the same address returns the write's data, merged lane by lane over the old word according to the write's byte selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cen_n | input | 1 | Clock enable, active low; high stalls the block |
| cs_n | input | 1 | Combined chip select, active low |
| adv_ld | input | 1 | 1 = continue burst, 0 = load new command |
| we_n | input | 1 | Write enable on load cycles, active low |
| bws_n | input | 4 | Byte-lane write selects, active low |
| addr | input | AW | Word address |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low |
| dq_i | input | 32 | Write data from the bus |
| dq_o | output | 32 | Read data to the bus |
| dq_t | output | 1 | Drive enable for the bus pins |

## Verification
A command sampled at valid edge k uses the bus between valid edges k+1 and k+2. Its read word appears after edge k+1, and its write word is captured at edge k+2. Stalled edges do not count toward k. The bench drives inputs on the falling edge and updates its own model only on rising edges where `cen_n` is low. The model holds two pending slots, and it checks `dq_o` and `dq_t` on every falling edge against the slot the model has in the output stage. As a result, stalls, `oe_n` changes and deselects are all checked in the slot where their effect is due.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int LANES   = 4;
    localparam int BYTE_W  = 8;
    localparam int DATA_W  = LANES * BYTE_W;
    localparam int BL_BITS = 2;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Offset inside the aligned burst group for step n from start.
    function automatic logic [BL_BITS-1:0] burst_ofs(
        input logic [BL_BITS-1:0] start,
        input logic [BL_BITS-1:0] n,
        input logic               ilv
    );
        return ilv ? (start ^ n) : (start + n);
    endfunction

    function automatic op_e load_op(input logic we_n);
        return we_n ? OP_RD : OP_WR;
    endfunction

endpackage

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq
    import pbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          adv,
    input  logic          sel,
    input  logic          we_n,
    input  logic          ilv,
    input  logic [AW-1:0] addr,
    output op_e           op_o,
    output logic [AW-1:0] addr_o
);
    localparam int HI_W = AW - BL_BITS;

    op_e                last_q;
    logic [HI_W-1:0]    hi_q;
    logic [BL_BITS-1:0] start_q;
    logic [BL_BITS-1:0] cnt_q;
    logic               ilv_q;
    logic [BL_BITS-1:0] cnt_nx;

    assign cnt_nx = cnt_q + BL_BITS'(1);

    always_comb begin
        op_o   = OP_NONE;
        addr_o = addr;
        if (adv) begin
            op_o   = last_q;
            addr_o = {hi_q, burst_ofs(start_q, cnt_nx, ilv_q)};
        end else if (sel) begin
            op_o = load_op(we_n);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= OP_NONE;
            hi_q    <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            ilv_q   <= 1'b0;
        end else if (step) begin
            if (adv) begin
                cnt_q <= cnt_nx;
            end else begin
                last_q  <= sel ? load_op(we_n) : OP_NONE;
                hi_q    <= addr[AW-1:BL_BITS];
                start_q <= addr[BL_BITS-1:0];
                cnt_q   <= '0;
                ilv_q   <= ilv;
            end
        end
    end

    // R5
    burst_type_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (step && adv) |=> (last_q == $past(last_q)));

endmodule

// File: rtl/pbs_mem.sv
module pbs_mem
    import pbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              step,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [LANES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic fwd_hit;
    assign fwd_hit = wr_en && (wr_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];
        logic              lane_wr;

        assign lane_wr = step && wr_en && wr_be[g];

        always_ff @(posedge clk) begin
            if (lane_wr) cells[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
        end

        assign rd_data[g*BYTE_W +: BYTE_W] = (fwd_hit && wr_be[g])
            ? wr_data[g*BYTE_W +: BYTE_W] : cells[rd_addr];
    end

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
    import pbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen_n,
    input  logic              cs_n,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic [LANES-1:0]  bws_n,
    input  logic [AW-1:0]     addr,
    input  logic              burst_ilv,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_t
);
    typedef struct packed {
        op_e              op;
        logic [AW-1:0]    addr;
        logic [LANES-1:0] be;
    } slot_t;

    logic              step;
    op_e               cmd_op;
    logic [AW-1:0]     cmd_addr;
    slot_t             s1_q, s2_q;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] dout_q;

    assign step = !cen_n;

    pbs_burst_seq #(.AW(AW)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .adv    (adv_ld),
        .sel    (!cs_n),
        .we_n   (we_n),
        .ilv    (burst_ilv),
        .addr   (addr),
        .op_o   (cmd_op),
        .addr_o (cmd_addr)
    );

    pbs_mem #(.AW(AW)) u_mem (
        .clk     (clk),
        .step    (step),
        .wr_en   (s2_q.op == OP_WR),
        .wr_addr (s2_q.addr),
        .wr_be   (s2_q.be),
        .wr_data (dq_i),
        .rd_addr (s1_q.addr),
        .rd_data (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '{op: OP_NONE, addr: '0, be: '0};
            s2_q   <= '{op: OP_NONE, addr: '0, be: '0};
            dout_q <= '0;
        end else if (step) begin
            s1_q <= '{op: cmd_op, addr: cmd_addr, be: ~bws_n};
            s2_q <= s1_q;
            if (s1_q.op == OP_RD) dout_q <= rd_word;
        end
    end

    assign dq_o = dout_q;
    assign dq_t = (s2_q.op == OP_RD) && !oe_n;

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cen_n |=> ($stable(s1_q) && $stable(s2_q) && $stable(dout_q)));

    // R9
    deselect_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cen_n && !adv_ld && cs_n) |=> (s1_q.op == OP_NONE));

    // R10
    drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
        dq_t |-> !oe_n);

endmodule

// File: tb/pipe_burst_sram_tb.sv
module pipe_burst_sram_tb;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cen_n = 1'b1, cs_n = 1'b1, adv_ld = 1'b0, we_n = 1'b1;
    logic        oe_n = 1'b0, burst_ilv = 1'b0;
    logic [3:0]  bws_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [31:0] dq_i = '0;
    logic [31:0] dq_o;
    logic        dq_t;

    always #2 clk = ~clk;

    pipe_burst_sram #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .cen_n(cen_n), .cs_n(cs_n), .adv_ld(adv_ld),
        .we_n(we_n), .bws_n(bws_n), .addr(addr), .burst_ilv(burst_ilv),
        .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_t(dq_t)
    );

    int total = 0;
    int bad = 0;
    logic [31:0] mdl [DEPTH];
    // model slots: op 0 none, 1 read, 2 write
    int m1_op = 0, m2_op = 0, m1_a = 0, m2_a = 0;
    logic [3:0]  m1_be = 0, m2_be = 0;
    logic [31:0] m1_d = 0, m2_d = 0;
    string m1_tag = "R9", m2_tag = "R9";
    int last_op = 0, base_hi = 0, st = 0, cnt = 0;
    bit ilv_q = 0;
    logic [31:0] seed = 32'h1234_5678;
    int junk = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_out();
        if (m2_op == 1 && !oe_n) begin
            chk(dq_t === 1'b1, m2_tag, {31'd0, dq_t}, 32'd1);
            chk(dq_o === m2_d, m2_tag, dq_o, m2_d);
        end else if (m2_op == 1) begin
            chk(dq_t === 1'b0, "R10", {31'd0, dq_t}, 32'd0);
        end else begin
            chk(dq_t === 1'b0, (m2_op == 0) ? "R9" : m2_tag, {31'd0, dq_t}, 32'd0);
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic model_update(input string tag);
        int op, na;
        logic [31:0] nd;
        if (m2_op == 2) begin
            for (int i = 0; i < 4; i++)
                if (m2_be[i]) mdl[m2_a][i*8 +: 8] = dq_i[i*8 +: 8];
        end
        op = 0; na = 0; nd = '0;
        if (adv_ld) begin
            op = last_op;
            if (op != 0) begin
                cnt = (cnt + 1) % 4;
                na = base_hi * 4 + (ilv_q ? (st ^ cnt) : ((st + cnt) % 4));
            end
        end else if (!cs_n) begin
            op = we_n ? 1 : 2;
            na = int'(addr);
            base_hi = na / 4; st = na % 4; cnt = 0; ilv_q = burst_ilv;
            last_op = op;
        end else begin
            last_op = 0;
        end
        if (op == 2) nd = next_rand();
        if (m1_op == 1) m1_d = mdl[m1_a];
        m2_op = m1_op; m2_a = m1_a; m2_be = m1_be; m2_d = m1_d; m2_tag = m1_tag;
        m1_op = op; m1_a = na; m1_be = ~bws_n; m1_d = nd; m1_tag = tag;
    endtask

    task automatic cyc(input bit cen, input bit cs, input bit adv, input bit we,
                       input logic [3:0] ben, input int a, input bit md,
                       input bit oe, input string tag);
        @(negedge clk);
        oe_n = oe;
        #1;
        check_out();
        cen_n = cen; cs_n = cs; adv_ld = adv; we_n = we; bws_n = ben;
        addr = AW'(a); burst_ilv = md;
        junk++;
        dq_i = (!cen && m1_op == 2) ? m1_d : (32'hDEAD_0000 | 32'(junk));
        @(posedge clk);
        if (!cen) model_update(tag);
    endtask

    task automatic flush(input string tag);
        repeat (3) cyc(0, 1, 0, 1, 4'hF, 0, 0, 0, tag);
    endtask

    initial begin
        // R1: outputs idle through reset even with oe_n low
        repeat (3) begin
            @(negedge clk);
            chk(dq_t === 1'b0, "R1", {31'd0, dq_t}, 32'd0);
        end
        rst = 1'b0;
        @(negedge clk);
        chk(dq_t === 1'b0, "R1", {31'd0, dq_t}, 32'd0);
        cyc(1, 0, 0, 1, 4'hF, 0, 0, 0, "R1");
        chk(dq_t === 1'b0, "R1", {31'd0, dq_t}, 32'd0);

        // R4: fill every word with full-lane writes
        for (int a = 0; a < DEPTH; a++) cyc(0, 0, 0, 0, 4'h0, a, 0, 0, "R4");
        // R3: read back every word, back to back
        for (int a = 0; a < DEPTH; a++) cyc(0, 0, 0, 1, 4'hF, a, 0, 0, "R3");
        // R4: every lane mask pattern
        for (int a = 0; a < 16; a++) cyc(0, 0, 0, 0, 4'(a), a, 0, 0, "R4");
        for (int a = 0; a < 16; a++) cyc(0, 0, 0, 1, 4'hF, a, 0, 0, "R4");

        // R6/R7/R8/R5: bursts in both orders from every start offset
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                int base;
                base = 16 + md * 16 + s * 4 + s;
                cyc(0, 0, 0, 0, 4'h0, base, md[0], 0, "R8");
                for (int n = 1; n < 6; n++)
                    cyc(0, n[0], 1, n[1], 4'(n * 5), 63 - n, !md[0], 0, "R8");
                cyc(0, 0, 0, 1, 4'hF, base, md[0], 0, md ? "R7" : "R6");
                for (int n = 1; n < 6; n++)
                    cyc(0, n[0], 1, !n[1], 4'(n), 7 * n, !md[0], 0, "R5");
            end
        end
        flush("R9");

        // R5: continuing after a deselect accesses nothing
        cyc(0, 1, 0, 1, 4'hF, 3, 0, 0, "R9");
        for (int n = 0; n < 4; n++) cyc(0, 0, 1, n[0], 4'h0, n, 0, 0, "R5");
        flush("R9");

        // R11: read right after write to the same word, partial lanes
        for (int a = 0; a < 16; a++) begin
            cyc(0, 0, 0, 0, 4'(a ^ 5), 40 + (a % 8), 0, 0, "R11");
            cyc(0, 0, 0, 1, 4'hF, 40 + (a % 8), 0, 0, "R11");
        end
        flush("R9");

        // R10: reads with output enable toggling
        for (int a = 0; a < 24; a++) cyc(0, 0, 0, 1, 4'hF, a, 0, a[0], "R10");
        flush("R10");

        // R2: mixed traffic with stalls and junk on stalled edges
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            bit stall;
            r = next_rand();
            stall = (r[31:29] == 3'd0) || (i % 7 == 3);
            if (stall)
                cyc(1, r[3], r[4], r[5], r[9:6], int'(r[15:10]), r[16], r[17] & r[18], "R2");
            else case (r[22:20])
                3'd0, 3'd1: cyc(0, 0, 0, 1, r[9:6], int'(r[15:10]), r[16], r[17] & r[18], "R2");
                3'd2, 3'd3: cyc(0, 0, 0, 0, r[9:6], int'(r[15:10]), r[16], r[17] & r[18], "R2");
                3'd4, 3'd5, 3'd6: cyc(0, r[3], 1, r[5], r[9:6], int'(r[15:10]), r[16], r[17] & r[18], "R2");
                default: cyc(0, 1, 0, r[5], r[9:6], int'(r[15:10]), r[16], r[17] & r[18], "R9");
            endcase
        end
        flush("R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog R2 act=%h exp=%h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule